// File: doc/BRIEF.md
# UART Status Flag Controller

This block keeps the status flags of a serial port and decides when each one sets and clears. The transmit and receive datapaths report events to it as single-cycle pulses: a frame has finished shifting out, a frame has landed in the receive buffer, noise was seen, a stop bit was sampled low, or the line stayed quiet for a whole frame time. The transmit buffer state arrives as a level. Software reaches the flags through a status read strobe, a status write with data, and a data register read strobe. It sets the interrupt enables through a small control write.

There are two ways to clear a flag. Transmission-complete and receive-buffer-not-empty clear when software writes a 0 to their bit. The idle, overrun, noise and framing flags clear only when a status read is followed by a data read. The status read takes a snapshot of these four flags, and the next data read clears only the flags in that snapshot. A flag that sets between the two reads survives. When a frame arrives while the receive buffer is still full, the block raises overrun and withholds the buffer load strobe, so the stored data is kept. One interrupt line combines all enabled, asserted sources.

Top module: `uart_flag_ctrl`

## Requirements
- R1: After reset, `stat_o` reads 8'hC0, with bit 7 (transmit buffer empty) and bit 6 (transmission complete) set and all other bits 0. `ien_o` reads 0 and `irq_o` reads 0.
- R2: Bit 7 of `stat_o` shows the value of `tbe_i` registered on the previous clock edge.
- R3: Bit 6 (TC) sets on the edge after `tx_done_i` if bit 7 is 1 at that edge. `tx_done_i` while bit 7 is 0 leaves bit 6 unchanged.
- R4: A status write with data bit 6 equal to 0 clears TC, and data bit 5 equal to 0 clears bit 5 (RBNE). Writing 1 has no effect, and a status write never changes bits 7 or 4..1. Bit 0 always reads 0.
- R5: Bit 5 (RBNE) sets on the edge after `rx_done_i` and clears on the edge after `data_rd_i`. `rx_load_o` is high in the same cycle as `rx_done_i` when RBNE is 0.
- R6: `rx_done_i` while RBNE is 1 sets bit 3 (overrun) and holds `rx_load_o` low. RBNE stays 1.
- R7: `rx_idle_i` sets bit 4, `rx_noise_i` sets bit 2 and `rx_ferr_i` sets bit 1, each on the following edge.
- R8: Bits 4..1 clear only when a data read follows a status read. Only the bits that were 1 when the status read was sampled are cleared. A data read with no prior status read, or a flag set after the status read, is not cleared.
- R9: When a set event and a clear occur in the same cycle for one flag, the flag ends up set.
- R10: `ctrl_wr_i` loads `ien_o` from `ctrl_wdata_i`, with bit 0 as the error enable, bit 1 idle, bit 2 RBNE and bit 3 TC. `irq_o` is high exactly when TC&ien[3], RBNE&ien[2], IDLE&ien[1], or (any of bits 3..1)&ien[0] holds. It follows `stat_o` and `ien_o` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tbe_i | input | 1 | Transmit buffer empty level from the transmit path |
| tx_done_i | input | 1 | Pulse: frame finished shifting out |
| rx_done_i | input | 1 | Pulse: received frame ready for the buffer |
| rx_noise_i | input | 1 | Pulse: noise detected during a frame |
| rx_ferr_i | input | 1 | Pulse: stop bit sampled low |
| rx_idle_i | input | 1 | Pulse: line idle for one frame time |
| stat_rd_i | input | 1 | Status register read strobe |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | 8 | Status write data |
| data_rd_i | input | 1 | Data register read strobe |
| ctrl_wr_i | input | 1 | Interrupt enable write strobe |
| ctrl_wdata_i | input | 4 | Interrupt enable write data |
| stat_o | output | 8 | Status word |
| ien_o | output | 4 | Interrupt enables |
| irq_o | output | 1 | Combined interrupt |
| rx_load_o | output | 1 | Permit to load the received frame into the buffer |

## Verification
Every flag and every enable is registered, so its result is due on the first clock edge after the stimulus. `irq_o` follows the registered state in that same cycle. `rx_load_o` is combinational and is due in the cycle of `rx_done_i`.

The bench drives inputs after the falling edge. It checks `rx_load_o` shortly after driving, then advances its reference model at the rising edge. It compares `stat_o`, `ien_o` and `irq_o` at the next falling edge. Directed sequences cover the snapshot rule, same-cycle set/clear and writes of all ones.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int STAT_W   = 8;
  localparam int IEN_W    = 4;
  localparam int SEQ_N    = 4;   // flags cleared by status-then-data read
  localparam int SEQ_LSB  = 1;   // bit position of the first of them
  localparam int TBE_B    = 7;
  localparam int TC_B     = 6;
  localparam int RBNE_B   = 5;
  localparam int IE_ERR   = 0;
  localparam int IE_IDLE  = 1;
  localparam int IE_RBNE  = 2;
  localparam int IE_TC    = 3;
  localparam int SRC_N    = 4;
endpackage

// File: rtl/uart_flag_bit.sv
module uart_flag_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= RST_VAL;
    else if (set_i)  q_o <= 1'b1;   // set wins over clear
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/uart_seq_clear.sv
module uart_seq_clear #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flags_i,
  input  logic         stat_rd_i,
  input  logic         data_rd_i,
  output logic [N-1:0] clr_o
);
  logic [N-1:0] snap_q;

  // snapshot of flags seen by the status read; consumed by next data read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (stat_rd_i) snap_q <= flags_i;
    else if (data_rd_i) snap_q <= '0;
  end

  assign clr_o = data_rd_i ? snap_q : '0;
endmodule

// File: rtl/uart_irq_comb.sv
module uart_irq_comb #(
  parameter int N = 4
) (
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  assign irq_o = |(src_i & en_i);
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
  import uart_flag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbe_i,
  input  logic              tx_done_i,
  input  logic              rx_done_i,
  input  logic              rx_noise_i,
  input  logic              rx_ferr_i,
  input  logic              rx_idle_i,
  input  logic              stat_rd_i,
  input  logic              stat_wr_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  input  logic              data_rd_i,
  input  logic              ctrl_wr_i,
  input  logic [IEN_W-1:0]  ctrl_wdata_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [IEN_W-1:0]  ien_o,
  output logic              irq_o,
  output logic              rx_load_o
);
  localparam logic [STAT_W-1:0] W0_MASK = (STAT_W'(1) << TC_B) | (STAT_W'(1) << RBNE_B);

  logic              tbe_q, tc_q, rbne_q, ovr_set;
  logic [STAT_W-1:0] wr_clr;
  logic [SEQ_N-1:0]  seq_q, seq_set, seq_clr;
  logic [IEN_W-1:0]  ien_q;
  logic [SRC_N-1:0]  irq_src;

  assign wr_clr = stat_wr_i ? (~stat_wdata_i & W0_MASK) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tbe_q <= 1'b1;
    else         tbe_q <= tbe_i;
  end

  uart_flag_bit #(.RST_VAL(1'b1)) u_tc (
    .clk_i, .rst_ni,
    .set_i (tx_done_i & tbe_q),
    .clr_i (wr_clr[TC_B]),
    .q_o   (tc_q)
  );

  uart_flag_bit #(.RST_VAL(1'b0)) u_rbne (
    .clk_i, .rst_ni,
    .set_i (rx_done_i),
    .clr_i (wr_clr[RBNE_B] | data_rd_i),
    .q_o   (rbne_q)
  );

  // overrun: new frame while buffer still full, load withheld
  assign ovr_set   = rx_done_i & rbne_q;
  assign rx_load_o = rx_done_i & ~rbne_q;

  // index 0 framing, 1 noise, 2 overrun, 3 idle
  assign seq_set = {rx_idle_i, ovr_set, rx_noise_i, rx_ferr_i};

  uart_seq_clear #(.N(SEQ_N)) u_seq (
    .clk_i, .rst_ni,
    .flags_i   (seq_q),
    .stat_rd_i,
    .data_rd_i,
    .clr_o     (seq_clr)
  );

  for (genvar i = 0; i < SEQ_N; i++) begin : g_seq
    uart_flag_bit #(.RST_VAL(1'b0)) u_f (
      .clk_i, .rst_ni,
      .set_i (seq_set[i]),
      .clr_i (seq_clr[i]),
      .q_o   (seq_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ien_q <= '0;
    else if (ctrl_wr_i) ien_q <= ctrl_wdata_i;
  end

  always_comb begin
    stat_o = '0;
    stat_o[TBE_B]  = tbe_q;
    stat_o[TC_B]   = tc_q;
    stat_o[RBNE_B] = rbne_q;
    stat_o[SEQ_LSB +: SEQ_N] = seq_q;
  end

  assign irq_src[IE_ERR]  = |seq_q[2:0];
  assign irq_src[IE_IDLE] = seq_q[3];
  assign irq_src[IE_RBNE] = rbne_q;
  assign irq_src[IE_TC]   = tc_q;

  uart_irq_comb #(.N(SRC_N)) u_irq (
    .src_i (irq_src),
    .en_i  (ien_q),
    .irq_o
  );

  assign ien_o = ien_q;
endmodule

// File: rtl/uart_flag_chk.sv
module uart_flag_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tbe_i,
  input logic       tx_done_i,
  input logic       rx_done_i,
  input logic       stat_wr_i,
  input logic [7:0] stat_wdata_i,
  input logic       data_rd_i,
  input logic [7:0] stat_o,
  input logic [3:0] ien_o,
  input logic       irq_o,
  input logic       rx_load_o
);
  // R2
  tbe_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> stat_o[7] == $past(tbe_i));
  // R3
  tc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i && stat_o[7] |=> stat_o[6]);
  // R4
  wr_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr_i && stat_wdata_i[5] && stat_o[5] && !data_rd_i |=> stat_o[5]);
  // R6
  ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i && stat_o[5] |=> stat_o[3] && stat_o[5]);
  // R6
  no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i && stat_o[5] |-> !rx_load_o);
  // R8
  ovr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[3] && !data_rd_i |=> stat_o[3]);
  // R10
  irq_tc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[6] && ien_o[3] |-> irq_o);
  // R10
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_o == 4'h0 |-> !irq_o);
  // R4
  bit0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_o[0]);
endmodule

bind uart_flag_ctrl uart_flag_chk u_chk (
  .clk_i, .rst_ni, .tbe_i, .tx_done_i, .rx_done_i, .stat_wr_i,
  .stat_wdata_i, .data_rd_i, .stat_o, .ien_o, .irq_o, .rx_load_o
);

// File: tb/uart_flag_ctrl_tb.sv
module uart_flag_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tbe_i = 1'b1, tx_done_i = 0, rx_done_i = 0, rx_noise_i = 0;
  logic       rx_ferr_i = 0, rx_idle_i = 0, stat_rd_i = 0, stat_wr_i = 0;
  logic [7:0] stat_wdata_i = 0;
  logic       data_rd_i = 0, ctrl_wr_i = 0;
  logic [3:0] ctrl_wdata_i = 0;
  logic [7:0] stat_o;
  logic [3:0] ien_o;
  logic       irq_o, rx_load_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  logic m_tbe = 1, m_tc = 1, m_rbne = 0;
  logic [3:0] m_seq = 0, m_snap = 0, m_ien = 0;

  always #2 clk_i = ~clk_i;   // 250 MHz

  uart_flag_ctrl u_dut (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stat();
    return {m_tbe, m_tc, m_rbne, m_seq, 1'b0};
  endfunction

  function automatic logic exp_irq();
    return (m_tc & m_ien[3]) | (m_rbne & m_ien[2]) | (m_seq[3] & m_ien[1]) |
           ((|m_seq[2:0]) & m_ien[0]);
  endfunction

  task automatic model_step();
    logic       ovr;
    logic [3:0] sset, sclr;
    ovr  = rx_done_i & m_rbne;
    sset = {rx_idle_i, ovr, rx_noise_i, rx_ferr_i};
    sclr = data_rd_i ? m_snap : 4'h0;
    m_snap = stat_rd_i ? m_seq : (data_rd_i ? 4'h0 : m_snap);
    m_seq  = sset | (m_seq & ~sclr);
    m_tc   = (tx_done_i & m_tbe) | (m_tc & ~(stat_wr_i & ~stat_wdata_i[6]));
    m_rbne = rx_done_i | (m_rbne & ~((stat_wr_i & ~stat_wdata_i[5]) | data_rd_i));
    m_tbe  = tbe_i;
    if (ctrl_wr_i) m_ien = ctrl_wdata_i;
  endtask

  task automatic clear_in();
    {tx_done_i, rx_done_i, rx_noise_i, rx_ferr_i, rx_idle_i} = '0;
    {stat_rd_i, stat_wr_i, data_rd_i, ctrl_wr_i} = '0;
  endtask

  // inputs already driven after a falling edge
  task automatic cycle();
    #1;
    chk("R5/R6 rx_load", {7'h0, rx_load_o}, {7'h0, rx_done_i & ~m_rbne});
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    chk("R2 tbe",        {7'h0, stat_o[7]}, {7'h0, m_tbe});
    chk("R3/R4 tc",      {7'h0, stat_o[6]}, {7'h0, m_tc});
    chk("R5/R9 rbne",    {7'h0, stat_o[5]}, {7'h0, m_rbne});
    chk("R7/R8 seq",     {4'h0, stat_o[4:1]}, {4'h0, m_seq});
    chk("R10 ien",       {4'h0, ien_o}, {4'h0, m_ien});
    chk("R10 irq",       {7'h0, irq_o}, {7'h0, exp_irq()});
    clear_in();
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    #7 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk("R1 reset stat", stat_o, 8'hC0);
    chk("R1 reset ien", {4'h0, ien_o}, 8'h00);
    chk("R1 reset irq", {7'h0, irq_o}, 8'h00);

    // R4: writing ones changes nothing
    stat_wr_i = 1; stat_wdata_i = 8'hFF; cycle();
    chk("R4 write ones", stat_o, 8'hC0);
    // R4: write zero clears TC only
    stat_wr_i = 1; stat_wdata_i = 8'h00; cycle();
    chk("R4 write zero", stat_o, 8'h80);
    // R3: tx_done with buffer not empty does not set TC
    tbe_i = 0; cycle();
    tx_done_i = 1; cycle();
    chk("R3 no set when tbe low", {7'h0, stat_o[6]}, 8'h00);
    tbe_i = 1; cycle();
    tx_done_i = 1; cycle();
    chk("R3 set", {7'h0, stat_o[6]}, 8'h01);

    // R5 / R6
    rx_done_i = 1; cycle();
    rx_done_i = 1; cycle();
    chk("R6 overrun", stat_o[5:3], 3'b101);
    // R9: data read and new frame in same cycle
    rx_done_i = 1; data_rd_i = 1; cycle();
    chk("R9 set wins", {7'h0, stat_o[5]}, 8'h01);
    data_rd_i = 1; cycle();
    // R8: data read alone does not clear overrun
    chk("R8 data read alone", {7'h0, stat_o[3]}, 8'h01);

    // R7 / R8 snapshot
    rx_noise_i = 1; cycle();
    stat_rd_i = 1; cycle();
    rx_ferr_i = 1; rx_idle_i = 1; cycle();
    data_rd_i = 1; cycle();
    chk("R8 snapshot clear", {4'h0, stat_o[4:1]}, 8'h09);
    stat_rd_i = 1; cycle();
    data_rd_i = 1; cycle();
    chk("R8 second sequence", {4'h0, stat_o[4:1]}, 8'h00);

    // R10 masking
    ctrl_wr_i = 1; ctrl_wdata_i = 4'b0010; rx_idle_i = 1; cycle();
    chk("R10 idle irq", {7'h0, irq_o}, 8'h01);
    ctrl_wr_i = 1; ctrl_wdata_i = 4'b0001; cycle();
    chk("R10 err masked", {7'h0, irq_o}, 8'h00);

    for (int n = 0; n < 3000; n++) begin
      tbe_i        = ($urandom % 4) != 0;
      tx_done_i    = ($urandom % 6) == 0;
      rx_done_i    = ($urandom % 5) == 0;
      rx_noise_i   = ($urandom % 12) == 0;
      rx_ferr_i    = ($urandom % 12) == 0;
      rx_idle_i    = ($urandom % 12) == 0;
      stat_rd_i    = ($urandom % 5) == 0;
      data_rd_i    = ($urandom % 5) == 0;
      stat_wr_i    = ($urandom % 8) == 0;
      stat_wdata_i = 8'($urandom);
      ctrl_wr_i    = ($urandom % 10) == 0;
      ctrl_wdata_i = 4'($urandom);
      cycle();
      if (done) break;
    end
    done = 1;
  end

  initial begin
    wait (done);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule